// File: doc/BRIEF.md
# Cross-Channel PWM Edge Generator

This block composes two gate drive outputs, A and B, from the transitions of four pulse-width source signals: the A and B outputs of its own channel and the A and B outputs of a neighbouring channel. Each output is a set/clear element. One programmable select chooses the edge that turns the output on. A second select chooses the edge that turns it off. Each select names either the rising or the falling edge of one of the four sources. This lets phase-shifted bridge waveforms be built from timing that other channels already produce.

The sources are registered once. Edges are found by comparing that copy with one earlier sample. The output state machine then advances on the next clock. A generator-enable input selects between composing mode and pass-through mode. In pass-through mode the outputs follow the own-channel A and B sources through the same two register stages. Every channel can therefore show the same delay whether its generator is used or not.

Each output has a two-state machine with the states GATE_LO and GATE_HI. Its transitions are:
- SET: GATE_LO to GATE_HI, on the selected turn-on edge when the turn-off edge is absent.
- CLEAR: GATE_HI to GATE_LO, on the selected turn-off edge.
- FOLLOW: in pass-through mode the state is loaded from the registered own source.

Top module: `edge_gen_top`

## Requirements
- R1: An active-low reset, which is asynchronous, forces both outputs low and clears all sampled source history.
- R2: A 3-bit select code picks an edge as follows. 0 is own A rising, 1 own A falling, 2 own B rising, 3 own B falling, 4 neighbour A rising, 5 neighbour A falling, 6 neighbour B rising, 7 neighbour B falling.
- R3: With the generator enabled, the edge picked by an output's turn-on select drives that output high.
- R4: With the generator enabled, the edge picked by an output's turn-off select drives that output low.
- R5: With the generator enabled, an output holds its value when neither of its selected edges occurs. Edges that are not selected have no effect.
- R6: When the turn-on and turn-off edges of one output are seen in the same clock, the output goes low.
- R7: A source change applied before clock edge k is visible at the outputs after clock edge k+1, which is two register stages.
- R8: With the generator disabled, out_a and out_b follow own_a and own_b with the same two-clock latency as in R7.
- R9: With selects A-on=2, A-off=5, B-on=6 and B-off=1, both outputs produce the expected composed bridge waveforms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | 1: compose from edges; 0: pass own sources through |
| sel_a_on | input | 3 | Edge code that turns out_a on |
| sel_a_off | input | 3 | Edge code that turns out_a off |
| sel_b_on | input | 3 | Edge code that turns out_b on |
| sel_b_off | input | 3 | Edge code that turns out_b off |
| own_a | input | 1 | Own channel A source |
| own_b | input | 1 | Own channel B source |
| nbr_a | input | 1 | Neighbour channel A source |
| nbr_b | input | 1 | Neighbour channel B source |
| out_a | output | 1 | Composed gate output A |
| out_b | output | 1 | Composed gate output B |

## Verification
A corrupted source history would produce phantom or missed edges. These show as an output that sets or clears on the wrong vector, or that fails to hold, within two clocks of the offending input change. An error in the state machine shows as a wrong level at the first step after a SET or CLEAR should have happened. It also shows when simultaneous on and off edges leave an output high. A latency mismatch between the modes shows at the first sample after gen_en changes, because the pass-through value appears one clock early or late.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;
    localparam int SRC_N = 4;
    localparam int EVT_N = 2 * SRC_N;
    localparam int SEL_W = $clog2(EVT_N);

    typedef enum logic {
        GATE_LO = 1'b0,
        GATE_HI = 1'b1
    } gate_state_t;

    typedef logic [SEL_W-1:0] edge_sel_t;
endpackage

// File: rtl/src_edge_detect.sv
module src_edge_detect
    import pwm_edge_pkg::*;
#(
    parameter int N = SRC_N,
    localparam int EN = 2 * N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_in,
    output logic [N-1:0] src_q,
    output logic [EN-1:0] evt
);
    logic [N-1:0] src_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q    <= '0;
            src_prev <= '0;
        end else begin
            src_q    <= src_in;
            src_prev <= src_q;
        end
    end

    // even index: rising edge of source i, odd index: falling edge
    for (genvar i = 0; i < N; i++) begin : g_evt
        assign evt[2*i]   =  src_q[i] & ~src_prev[i];
        assign evt[2*i+1] = ~src_q[i] &  src_prev[i];
    end
endmodule

// File: rtl/gate_sr_fsm.sv
module gate_sr_fsm
    import pwm_edge_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  edge_sel_t        sel_on,
    input  edge_sel_t        sel_off,
    input  logic [EVT_N-1:0] evt,
    input  logic             pass_in,
    output logic             gate_out
);
    gate_state_t state_q, state_d;
    logic        on_hit, off_hit;

    assign on_hit  = evt[sel_on];
    assign off_hit = evt[sel_off];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!gen_en) begin
            state_d = pass_in ? GATE_HI : GATE_LO;          // FOLLOW
        end else begin
            unique case (state_q)
                GATE_LO: if (on_hit && !off_hit) state_d = GATE_HI;  // SET
                GATE_HI: if (off_hit)            state_d = GATE_LO;  // CLEAR
                default: state_d = GATE_LO;
            endcase
        end
    end

    always_comb begin
        gate_out = (state_q == GATE_HI);
    end

    AST_ON_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        gen_en && on_hit && !off_hit |=> state_q == GATE_HI); // R3
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        gen_en && off_hit && !on_hit |=> state_q == GATE_LO); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        gen_en && !on_hit && !off_hit |=> $stable(state_q)); // R5
    AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        gen_en && on_hit && off_hit |=> state_q == GATE_LO); // R6
    AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> gate_out == $past(pass_in)); // R8
endmodule

// File: rtl/edge_gen_top.sv
module edge_gen_top
    import pwm_edge_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gen_en,
    input  logic [2:0] sel_a_on,
    input  logic [2:0] sel_a_off,
    input  logic [2:0] sel_b_on,
    input  logic [2:0] sel_b_off,
    input  logic       own_a,
    input  logic       own_b,
    input  logic       nbr_a,
    input  logic       nbr_b,
    output logic       out_a,
    output logic       out_b
);
    localparam int OUT_N = 2;

    logic [SRC_N-1:0] src_in, src_q;
    logic [EVT_N-1:0] evt;
    edge_sel_t        sel_on  [OUT_N];
    edge_sel_t        sel_off [OUT_N];
    logic [OUT_N-1:0] gate;

    // source order fixes the edge code map: code = 2*index + falling
    assign src_in = {nbr_b, nbr_a, own_b, own_a};

    assign sel_on[0]  = sel_a_on;
    assign sel_off[0] = sel_a_off;
    assign sel_on[1]  = sel_b_on;
    assign sel_off[1] = sel_b_off;

    src_edge_detect #(.N(SRC_N)) u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_in (src_in),
        .src_q  (src_q),
        .evt    (evt)
    );

    for (genvar k = 0; k < OUT_N; k++) begin : g_gate
        gate_sr_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .gen_en   (gen_en),
            .sel_on   (sel_on[k]),
            .sel_off  (sel_off[k]),
            .evt      (evt),
            .pass_in  (src_q[k]),
            .gate_out (gate[k])
        );
    end

    assign out_a = gate[0];
    assign out_b = gate[1];

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |-> !out_a && !out_b); // R1
endmodule

// File: tb/sim_edge_gen_top.sv
module sim_edge_gen_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gen_en = 1'b1;
    logic [2:0] sel_a_on = 3'd2, sel_a_off = 3'd5, sel_b_on = 3'd6, sel_b_off = 3'd1;
    logic       own_a = 1'b0, own_b = 1'b0, nbr_a = 1'b0, nbr_b = 1'b0;
    logic       out_a, out_b;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_gen_top u0 (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en),
        .sel_a_on(sel_a_on), .sel_a_off(sel_a_off),
        .sel_b_on(sel_b_on), .sel_b_off(sel_b_off),
        .own_a(own_a), .own_b(own_b), .nbr_a(nbr_a), .nbr_b(nbr_b),
        .out_a(out_a), .out_b(out_b)
    );

    // {own_a, own_b, nbr_a, nbr_b, exp_a, exp_b}, selects 2/5/6/1 (R9)
    localparam logic [5:0] VEC [0:10] = '{
        6'b1000_00, 6'b1100_10, 6'b1110_10, 6'b1100_00,
        6'b1101_01, 6'b0101_00, 6'b0000_00, 6'b0101_11,
        6'b0000_11, 6'b1010_11, 6'b0000_00
    };

    task automatic chk(input string req, input logic ea, input logic eb);
        checks++;
        if (out_a !== ea || out_b !== eb) begin
            errors++;
            $display("FAIL %s: out_a/out_b=%b%b expected %b%b", req, out_a, out_b, ea, eb);
        end
    endtask

    task automatic drive(input logic oa, input logic ob, input logic na, input logic nb);
        @(negedge clk);
        own_a = oa; own_b = ob; nbr_a = na; nbr_b = nb;
    endtask

    task automatic wait2;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset low", 1'b0, 1'b0);
        rst_n = 1'b1;
        wait2;
        chk("R1 after release", 1'b0, 1'b0);

        // R9 table walk, also exercising R2..R5 with codes 1,2,5,6
        for (int i = 0; i < 11; i++) begin
            drive(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
            wait2;
            chk($sformatf("R9 vector %0d", i), VEC[i][1], VEC[i][0]);
        end

        // R6: A on = own A rising (0), A off = neighbour A rising (4)
        @(negedge clk); sel_a_on = 3'd0; sel_a_off = 3'd4;
        drive(1, 0, 0, 0); wait2; chk("R3 code0 sets A", 1'b1, 1'b0);
        drive(0, 0, 0, 0); wait2; chk("R5 unselected fall holds", 1'b1, 1'b0);
        drive(1, 0, 1, 0); wait2; chk("R6 off wins", 1'b0, 1'b0);

        // R2: B on = own B falling (3), B off = neighbour B falling (7)
        @(negedge clk); sel_b_on = 3'd3; sel_b_off = 3'd7;
        drive(1, 1, 1, 0); wait2; chk("R2 own B rise ignored", 1'b0, 1'b0);
        drive(1, 0, 1, 0); wait2; chk("R2 code3 sets B", 1'b0, 1'b1);
        drive(1, 0, 1, 1); wait2; chk("R2 nbr B rise ignored", 1'b0, 1'b1);
        drive(1, 0, 1, 0); wait2; chk("R2 code7 clears B", 1'b0, 1'b0);

        // R7 latency with target selects
        @(negedge clk); sel_a_on = 3'd2; sel_a_off = 3'd5; sel_b_on = 3'd6; sel_b_off = 3'd1;
        drive(1, 1, 1, 0);
        @(negedge clk); chk("R7 one clock: unchanged", 1'b0, 1'b0);
        @(negedge clk); chk("R7 two clocks: set", 1'b1, 1'b0);

        // R8 bypass
        @(negedge clk); gen_en = 1'b0;
        own_a = 1'b0; own_b = 1'b1;
        @(negedge clk); chk("R8 one clock: prior sample", 1'b1, 1'b1);
        @(negedge clk); chk("R8 follows own", 1'b0, 1'b1);
        drive(1, 0, 1, 0); wait2; chk("R8 follows own again", 1'b1, 1'b0);

        // R5 hold after re-enable
        @(negedge clk); gen_en = 1'b1;
        wait2; chk("R5 hold after enable", 1'b1, 1'b0);

        // R1 asynchronous reset mid-run
        #(CLK_PERIOD/4) rst_n = 1'b0;
        #1 chk("R1 async reset", 1'b0, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule